// File: doc/BRIEF.md
# Data Cache Link Master

This block moves data between a data cache and main memory. It uses a pair of FIFO-style links: an outgoing stream that carries addresses and data words, each tagged with one control bit, and an incoming stream that returns refill words.

It takes one request at a time from the cache controller. A request is one of three kinds:
- a load miss, which refills the line;
- a store, which goes out as one word (write-through);
- a load miss that must first evict a dirty line, which sends the whole line out as a burst in linear order and then refills.

Every word returned from memory is written into the cache array. The word holding the missed address is also forwarded to the execute stage. For a byte or halfword load, the block first picks the addressed lanes out of that word.

The request port is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle.

The outgoing link has no ready pin; its back-pressure signal is the FIFO full flag. The block pushes a word (`lo_valid` high) only in a cycle where `lo_full` is low. While the flag stays high, the same word is held and offered again.

On the incoming link, the block pops (`li_read`) only when `li_exists` is high and it is collecting a refill.

The refill can run in one of two orders:
- Linear mode sends a line-aligned request, and words arrive from word 0 upward.
- Critical-word-first mode sends a word-aligned request, and words arrive starting at the missed word, wrapping around the line.

Line write-back needs linear mode. Asking for write-back in critical-word-first mode stops elaboration with an error, as does a line length that is not a power of two.

Top module: `dlink_master`

## Requirements
- R1: `req_ready` is 1 only when the block is idle, which includes the state right after reset. A request is accepted on a cycle with `req_valid` and `req_ready` both high. While a request is in progress, `req_ready` stays 0 and the block neither pushes nor pops on behalf of any other request.
- R2: `lo_valid` is never 1 in a cycle where `lo_full` is 1. A word that is blocked is offered again unchanged. This holds even for the first word of a request: while the full flag stays high, nothing goes out.
- R3: A refill request is pushed with `lo_ctrl`=0. Its address is the missed address rounded down to the line boundary in linear mode (LINEAR=1), or to the 4-byte word boundary in critical-word-first mode (LINEAR=0).
- R4: After a refill request, the block pops exactly LINE_WORDS words. It pops only in cycles where `li_exists` is 1. The memory side must keep `li_exists` low for at least the one cycle that follows the request push.
- R5: Returned word k of a refill is written to the array with `arr_we`=1 and `arr_wdata` equal to the returned word. Its position `arr_word` is as follows:
  - linear mode: k;
  - critical-word-first mode: (missed word index + k) mod LINE_WORDS.
- R6: Each refill raises `ld_valid` exactly once. This happens in the same cycle as the array write of the word whose index equals the missed address's word index.
- R7: `ld_data` is the forwarded word's lanes selected by `req_size`, zero-extended:
  - 0 = byte: address bits [1:0]=0 selects bits 31:24, and 3 selects bits 7:0 (big-endian);
  - 1 = halfword: address bit 1 = 0 selects bits 31:16, and 1 selects bits 15:0; bit 0 is ignored;
  - 2 = the whole word.
- R8: A store (`req_write`=1) pushes two words: first the word-aligned address with `lo_ctrl`=1, then `req_wdata` with `lo_ctrl`=0.
- R9: With WRITEBACK=1 and `req_evict`=1 on a load, the block does three things in order:
  - it pushes `req_evict_addr` rounded down to the line boundary, with `lo_ctrl`=1;
  - it pushes LINE_WORDS data words with `lo_ctrl`=0, taken from `arr_rd_data` while `arr_rd_word` steps through 0, 1, … LINE_WORDS-1;
  - only after the whole burst has been pushed does it push the refill request.
- R10: With WRITEBACK=0, `req_evict` has no effect. A load with `req_evict`=1 pushes only the refill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load miss |
| req_evict | input | 1 | Load miss must first evict a dirty line |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | DW | Byte address of the access |
| req_wdata | input | DW | Store data |
| req_evict_addr | input | DW | Any byte address inside the victim line |
| lo_valid | output | 1 | Push to outgoing link |
| lo_full | input | 1 | Outgoing link full (back-pressure) |
| lo_ctrl | output | 1 | Control bit of the pushed word (1 = write address) |
| lo_data | output | DW | Pushed word |
| li_exists | input | 1 | Incoming link has a word |
| li_read | output | 1 | Pop from incoming link |
| li_data | input | DW | Incoming word |
| arr_we | output | 1 | Cache array write strobe |
| arr_word | output | log2(LINE_WORDS) | Word index within the line |
| arr_wdata | output | DW | Word written to the array |
| arr_rd_word | output | log2(LINE_WORDS) | Victim word index being read |
| arr_rd_data | input | DW | Victim word (combinational read) |
| ld_valid | output | 1 | Load result valid, one cycle |
| ld_data | output | DW | Load result, zero-extended |

## Verification
The bench sweeps every word offset, byte offset and access size in two builds: linear with write-back, and critical-word-first without it. It varies full-flag and exists-flag stall patterns throughout.

The sweep targets several corner cases, each paired with the failure a wrong design would show:
- **Wrap-around placement in critical-word-first mode:** a design that got it wrong would write refill words to shifted array slots.
- **Forwarding on the critical word:** a wrong design would forward the wrong word, or forward it twice.
- **Big-endian lane choice:** a reversed lane order gives byte-swapped loads.
- **Full flag held high from the first cycle:** a design that ignores back-pressure would push into a full FIFO.
- **Ordering of eviction bursts against the refill request:** an early refill would show up as a misordered push stream.
- **The evict flag in a build without write-back:** a spurious burst would appear as extra pushes.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WB_ADDR = 3'd1,
    ST_WB_DATA = 3'd2,
    ST_RD_REQ  = 3'd3,
    ST_RD_RX   = 3'd4,
    ST_WR_ADDR = 3'd5,
    ST_WR_DATA = 3'd6
  } state_e;

endpackage

// File: rtl/dlink_ctrl.sv
module dlink_ctrl
  import dlink_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int WIDXW      = 2,
  parameter bit LINEAR     = 1'b1,
  parameter bit WRITEBACK  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             req_write,
  input  logic             req_evict,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [WIDXW-1:0] crit_idx,
  output state_e           state,
  output logic [WIDXW-1:0] cnt,
  output logic [WIDXW-1:0] widx
);

  localparam logic [WIDXW-1:0] LAST = WIDXW'(LINE_WORDS - 1);

  state_e           state_n;
  logic [WIDXW-1:0] cnt_n;
  logic             last;

  assign last = (cnt == LAST);

  generate
    if (LINEAR) begin : g_lin
      assign widx = cnt;
    end else begin : g_cwf
      // power-of-two line: the add wraps around the line by itself
      assign widx = cnt + crit_idx;
    end
  endgenerate

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      ST_IDLE: begin
        cnt_n = '0;
        if (req_fire) begin
          if (req_write)                   state_n = ST_WR_ADDR;
          else if (req_evict && WRITEBACK) state_n = ST_WB_ADDR;
          else                             state_n = ST_RD_REQ;
        end
      end
      ST_WB_ADDR: if (push_ok) state_n = ST_WB_DATA;
      ST_WB_DATA: if (push_ok) begin
        cnt_n = cnt + 1'b1;
        if (last) begin
          cnt_n   = '0;
          state_n = ST_RD_REQ;
        end
      end
      ST_RD_REQ: if (push_ok) begin
        cnt_n   = '0;
        state_n = ST_RD_RX;
      end
      ST_RD_RX: if (pop_ok) begin
        cnt_n = cnt + 1'b1;
        if (last) begin
          cnt_n   = '0;
          state_n = ST_IDLE;
        end
      end
      ST_WR_ADDR: if (push_ok) state_n = ST_WR_DATA;
      ST_WR_DATA: if (push_ok) state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/dlink_txmux.sv
module dlink_txmux
  import dlink_pkg::*;
#(
  parameter int DW     = 32,
  parameter int OFFW   = 2,
  parameter int LINEB  = 4,
  parameter bit LINEAR = 1'b1
) (
  input  state_e          state,
  input  logic [DW-1:0]   addr,
  input  logic [DW-1:0]   evict_addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   victim_word,
  output logic            pushing,
  output logic            ctrl,
  output logic [DW-1:0]   data
);

  localparam logic [DW-1:0] WORD_MASK = ~((DW'(1) << OFFW) - DW'(1));
  localparam logic [DW-1:0] LINE_MASK = ~((DW'(1) << LINEB) - DW'(1));
  localparam logic [DW-1:0] RD_MASK   = LINEAR ? LINE_MASK : WORD_MASK;

  always_comb begin
    pushing = 1'b1;
    ctrl    = 1'b0;
    data    = '0;
    unique case (state)
      ST_WB_ADDR: begin ctrl = 1'b1; data = evict_addr & LINE_MASK; end
      ST_WB_DATA: data = victim_word;
      ST_RD_REQ:  data = addr & RD_MASK;
      ST_WR_ADDR: begin ctrl = 1'b1; data = addr & WORD_MASK; end
      ST_WR_DATA: data = wdata;
      default:    pushing = 1'b0;
    endcase
  end

endmodule

// File: rtl/dlink_lane.sv
module dlink_lane
  import dlink_pkg::*;
#(
  parameter int DW   = 32,
  parameter int OFFW = 2
) (
  input  logic [DW-1:0]   word,
  input  logic [OFFW-1:0] off,
  input  size_e           size,
  output logic [DW-1:0]   result
);

  localparam int NB = DW / 8;
  localparam int NH = NB / 2;

  int bsel;
  int hsel;

  // big-endian: offset 0 is the most significant byte
  assign bsel = NB - 1 - int'(off);
  assign hsel = NH - 1 - int'(off[OFFW-1:1]);

  always_comb begin
    unique case (size)
      SZ_BYTE: result = DW'(word[bsel*8 +: 8]);
      SZ_HALF: result = DW'(word[hsel*16 +: 16]);
      default: result = word;
    endcase
  end

endmodule

// File: rtl/dlink_master.sv
module dlink_master
  import dlink_pkg::*;
#(
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter bit LINEAR     = 1'b1,
  parameter bit WRITEBACK  = 1'b1,
  localparam int WIDXW     = $clog2(LINE_WORDS),
  localparam int OFFW      = $clog2(DW / 8),
  localparam int LINEB     = WIDXW + OFFW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_evict,
  input  logic [1:0]       req_size,
  input  logic [DW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    req_evict_addr,
  output logic             lo_valid,
  input  logic             lo_full,
  output logic             lo_ctrl,
  output logic [DW-1:0]    lo_data,
  input  logic             li_exists,
  output logic             li_read,
  input  logic [DW-1:0]    li_data,
  output logic             arr_we,
  output logic [WIDXW-1:0] arr_word,
  output logic [DW-1:0]    arr_wdata,
  output logic [WIDXW-1:0] arr_rd_word,
  input  logic [DW-1:0]    arr_rd_data,
  output logic             ld_valid,
  output logic [DW-1:0]    ld_data
);

  generate
    if (WRITEBACK && !LINEAR) begin : g_bad_mode
      $error("dlink_master: line write-back requires linear refill order");
    end
    if ((1 << WIDXW) != LINE_WORDS || LINE_WORDS < 2) begin : g_bad_line
      $error("dlink_master: LINE_WORDS must be a power of two, at least 2");
    end
  endgenerate

  state_e           state;
  logic [WIDXW-1:0] cnt;
  logic [WIDXW-1:0] widx;
  logic [WIDXW-1:0] crit_idx;
  logic             req_fire;
  logic             pushing;
  logic [DW-1:0]    a_addr;
  logic [DW-1:0]    a_wdata;
  logic [DW-1:0]    a_evict;
  size_e            a_size;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign crit_idx  = a_addr[LINEB-1:OFFW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_addr  <= '0;
      a_wdata <= '0;
      a_evict <= '0;
      a_size  <= SZ_WORD;
    end else if (req_fire) begin
      a_addr  <= req_addr;
      a_wdata <= req_wdata;
      a_evict <= req_evict_addr;
      a_size  <= size_e'(req_size);
    end
  end

  dlink_ctrl #(
    .LINE_WORDS(LINE_WORDS),
    .WIDXW     (WIDXW),
    .LINEAR    (LINEAR),
    .WRITEBACK (WRITEBACK)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .req_write(req_write),
    .req_evict(req_evict),
    .push_ok  (!lo_full),
    .pop_ok   (li_exists),
    .crit_idx (crit_idx),
    .state    (state),
    .cnt      (cnt),
    .widx     (widx)
  );

  dlink_txmux #(
    .DW    (DW),
    .OFFW  (OFFW),
    .LINEB (LINEB),
    .LINEAR(LINEAR)
  ) u_txmux (
    .state      (state),
    .addr       (a_addr),
    .evict_addr (a_evict),
    .wdata      (a_wdata),
    .victim_word(arr_rd_data),
    .pushing    (pushing),
    .ctrl       (lo_ctrl),
    .data       (lo_data)
  );

  assign lo_valid    = pushing && !lo_full;
  assign arr_rd_word = cnt;

  assign li_read   = (state == ST_RD_RX) && li_exists;
  assign arr_we    = li_read;
  assign arr_word  = widx;
  assign arr_wdata = li_data;
  assign ld_valid  = li_read && (widx == crit_idx);

  dlink_lane #(
    .DW  (DW),
    .OFFW(OFFW)
  ) u_lane (
    .word  (li_data),
    .off   (a_addr[OFFW-1:0]),
    .size  (a_size),
    .result(ld_data)
  );

endmodule

// File: rtl/dlink_master_chk.sv
module dlink_master_chk
  import dlink_pkg::*;
#(
  parameter int DW     = 32,
  parameter bit LINEAR = 1'b1,
  parameter int OFFW   = 2,
  parameter int LINEB  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          lo_valid,
  input logic          lo_full,
  input logic          lo_ctrl,
  input logic [DW-1:0] lo_data,
  input logic          li_exists,
  input logic          li_read,
  input logic          arr_we,
  input logic          ld_valid,
  input state_e        state
);

  localparam int            AL      = LINEAR ? LINEB : OFFW;
  localparam logic [DW-1:0] RD_LOW  = (DW'(1) << AL) - DW'(1);
  localparam logic [DW-1:0] WD_LOW  = (DW'(1) << OFFW) - DW'(1);

  logic rdreq_q;
  logic fwd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdreq_q  <= 1'b0;
      fwd_seen <= 1'b0;
    end else begin
      rdreq_q <= lo_valid && (state == ST_RD_REQ);
      if (req_valid && req_ready) fwd_seen <= 1'b0;
      else if (ld_valid)          fwd_seen <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!lo_valid && !li_read)); // R1
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid |-> !lo_full); // R2
  AST_RDREQ_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_valid && state == ST_RD_REQ) |-> (!lo_ctrl && (lo_data & RD_LOW) == '0)); // R3
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    li_read |-> li_exists); // R4
  AST_GAP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rdreq_q |-> !li_read); // R4
  AST_FWD_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> arr_we); // R6
  AST_FWD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !fwd_seen); // R6
  AST_WADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_valid && lo_ctrl) |-> ((lo_data & WD_LOW) == '0)); // R8

endmodule

bind dlink_master dlink_master_chk #(
  .DW    (DW),
  .LINEAR(LINEAR),
  .OFFW  (OFFW),
  .LINEB (LINEB)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .lo_valid (lo_valid),
  .lo_full  (lo_full),
  .lo_ctrl  (lo_ctrl),
  .lo_data  (lo_data),
  .li_exists(li_exists),
  .li_read  (li_read),
  .arr_we   (arr_we),
  .ld_valid (ld_valid),
  .state    (state)
);

// File: tb/dlink_master_bench.sv
`timescale 1ns/1ps
module dlink_master_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid[2], req_ready[2], req_write[2], req_evict[2];
  logic [1:0]  req_size[2];
  logic [31:0] req_addr[2], req_wdata[2], req_evict_addr[2];
  logic        lo_valid[2], lo_full[2], lo_ctrl[2];
  logic [31:0] lo_data[2];
  logic        li_exists[2], li_read[2];
  logic [31:0] li_data[2];
  logic        arr_we[2];
  logic [1:0]  arr_word[2], arr_rd_word[2];
  logic [31:0] arr_wdata[2], arr_rd_data[2];
  logic        ld_valid[2];
  logic [31:0] ld_data[2];

  int n_tests = 0;
  int n_fail  = 0;

  assign arr_rd_data[0] = 32'hC0DE0000 + 32'(arr_rd_word[0]);
  assign arr_rd_data[1] = 32'hC0DE0000 + 32'(arr_rd_word[1]);

  // d=0: linear refill with write-back; d=1: critical word first, write-through only
  dlink_master #(.LINEAR(1'b1), .WRITEBACK(1'b1)) u_dlink_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write[0]),
    .req_evict(req_evict[0]), .req_size(req_size[0]), .req_addr(req_addr[0]),
    .req_wdata(req_wdata[0]), .req_evict_addr(req_evict_addr[0]),
    .lo_valid(lo_valid[0]), .lo_full(lo_full[0]), .lo_ctrl(lo_ctrl[0]), .lo_data(lo_data[0]),
    .li_exists(li_exists[0]), .li_read(li_read[0]), .li_data(li_data[0]),
    .arr_we(arr_we[0]), .arr_word(arr_word[0]), .arr_wdata(arr_wdata[0]),
    .arr_rd_word(arr_rd_word[0]), .arr_rd_data(arr_rd_data[0]),
    .ld_valid(ld_valid[0]), .ld_data(ld_data[0]));

  dlink_master #(.LINEAR(1'b0), .WRITEBACK(1'b0)) u_dlink_master_cwf (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write[1]),
    .req_evict(req_evict[1]), .req_size(req_size[1]), .req_addr(req_addr[1]),
    .req_wdata(req_wdata[1]), .req_evict_addr(req_evict_addr[1]),
    .lo_valid(lo_valid[1]), .lo_full(lo_full[1]), .lo_ctrl(lo_ctrl[1]), .lo_data(lo_data[1]),
    .li_exists(li_exists[1]), .li_read(li_read[1]), .li_data(li_data[1]),
    .arr_we(arr_we[1]), .arr_word(arr_word[1]), .arr_wdata(arr_wdata[1]),
    .arr_rd_word(arr_rd_word[1]), .arr_rd_data(arr_rd_data[1]),
    .ld_valid(ld_valid[1]), .ld_data(ld_data[1]));

  function automatic logic [31:0] mem(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] off,
                                       input logic [1:0] sz);
    if (sz == 2'd0) return (w >> (8 * (3 - int'(off)))) & 32'hFF;
    if (sz == 2'd1) return off[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
    return w;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input int d, input bit wr, input bit ev, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic [31:0] ea, input int seed);
    logic [32:0] exp_q[$];
    logic [32:0] got_q[$];
    bit          lin = (d == 0);
    bit          wb  = (d == 0);
    logic [31:0] base = a & ~32'hF;
    int          crit = int'(a[3:2]);
    int          cyc = 0, sent = 0, rx_start = -1, first_push = -1;
    int          bad_full = 0, bad_pop = 0, bad_arr = 0, fwd = 0, early = 0;
    logic [31:0] fwd_val = '0;
    bit          done = 0, busy_ready = 0;
    string       tag;

    if (wr) begin
      exp_q.push_back({1'b1, a & ~32'h3});
      exp_q.push_back({1'b0, wd});
      tag = "R8";
    end else begin
      if (ev && wb) begin
        exp_q.push_back({1'b1, ea & ~32'hF});
        for (int i = 0; i < 4; i++) exp_q.push_back({1'b0, 32'hC0DE0000 + 32'(i)});
      end
      exp_q.push_back({1'b0, lin ? base : (a & ~32'h3)});
      tag = (ev && wb) ? "R9" : (ev ? "R10" : "R3");
    end

    @(negedge clk);
    req_valid[d] = 1'b1; req_write[d] = wr; req_evict[d] = ev; req_size[d] = sz;
    req_addr[d] = a; req_wdata[d] = wd; req_evict_addr[d] = ea;
    lo_full[d] = 1'b0; li_exists[d] = 1'b0;
    #1;
    chk(req_ready[d] == 1'b1, "R1", "ready when idle", 64'(req_ready[d]), 64'd1);

    while (cyc < 400) begin
      @(negedge clk);
      req_valid[d] = 1'b0;
      cyc++;
      done = wr ? (got_q.size() == 2) : (sent == 4 && got_q.size() == exp_q.size());
      if (req_ready[d] && done) break;
      if (req_ready[d]) busy_ready = 1;
      lo_full[d] = (seed != 0 && ((cyc * 3 + seed) % 4 == 0)) || (seed % 2 == 1 && cyc <= 3);
      li_exists[d] = 1'b0;
      if (rx_start >= 0 && cyc >= rx_start && sent < 4 &&
          !(seed != 0 && (cyc + seed) % 3 == 0)) begin
        li_exists[d] = 1'b1;
        li_data[d] = mem(base + 32'(4 * (lin ? sent : (crit + sent) % 4)));
      end
      #1;
      if (lo_valid[d]) begin
        if (lo_full[d]) bad_full++;
        if (first_push < 0) first_push = cyc;
        got_q.push_back({lo_ctrl[d], lo_data[d]});
        if (!wr && got_q.size() == exp_q.size()) rx_start = cyc + 2;
      end
      if (li_read[d]) begin
        if (!li_exists[d]) bad_pop++;
        if (rx_start < 0 || cyc < rx_start) early++;
        sent++;
      end
      if (arr_we[d]) begin
        if (arr_wdata[d] != mem(base + 32'(4 * int'(arr_word[d])))) bad_arr++;
        if (arr_word[d] != 2'((lin ? sent - 1 : crit + sent - 1) % 4)) bad_arr++;
      end
      if (ld_valid[d]) begin
        fwd++;
        fwd_val = ld_data[d];
      end
    end
    lo_full[d] = 1'b0; li_exists[d] = 1'b0;

    chk(done, "R1", "request completes", 64'(cyc), 64'd0);
    chk(!busy_ready, "R1", "ready low while busy", 64'(busy_ready), 64'd0);
    chk(bad_full == 0, "R2", "push while full", 64'(bad_full), 64'd0);
    if (seed % 2 == 1)
      chk(first_push >= 4, "R2", "first push held by full", 64'(first_push), 64'd4);
    chk(got_q.size() == exp_q.size(), tag, "push count", 64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], tag, $sformatf("push %0d", i), 64'(got_q[i]), 64'(exp_q[i]));
    if (!wr) begin
      chk(sent == 4 && bad_pop == 0 && early == 0, "R4", "pops", 64'(sent), 64'd4);
      chk(bad_arr == 0, "R5", "array placement", 64'(bad_arr), 64'd0);
      chk(fwd == 1, "R6", "forward count", 64'(fwd), 64'd1);
      chk(fwd_val == pick(mem(a), a[1:0], sz), "R7", $sformatf("lane sz=%0d a=%0h", sz, a),
          64'(fwd_val), 64'(pick(mem(a), a[1:0], sz)));
    end else begin
      chk(sent == 0 && fwd == 0, "R8", "store pops nothing", 64'(sent), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      req_valid[d] = 0; req_write[d] = 0; req_evict[d] = 0; req_size[d] = 0;
      req_addr[d] = 0; req_wdata[d] = 0; req_evict_addr[d] = 0;
      lo_full[d] = 0; li_exists[d] = 0; li_data[d] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int d = 0; d < 2; d++) begin
      chk(req_ready[d] == 1'b1, "R1", "reset ready", 64'(req_ready[d]), 64'd1);
      chk(!lo_valid[d] && !li_read[d] && !arr_we[d] && !ld_valid[d], "R1", "reset quiet",
          64'({lo_valid[d], li_read[d], arr_we[d], ld_valid[d]}), 64'd0);
    end

    // R3 R5 R6 R7: every word offset, byte offset and size in both builds
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 4; w++)
        for (int b = 0; b < 4; b++)
          for (int s = 0; s < 3; s++)
            run_op(d, 1'b0, 1'b0, 2'(s), 32'h0000_2000 + 32'(64 * (w * 4 + b)) + 32'(4 * w + b),
                   32'h0, 32'h0, (w + b + s + d) % 5);

    // R9 / R10: eviction in each build
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 4; w++)
        run_op(d, 1'b0, 1'b1, 2'd2, 32'h0000_5A00 + 32'(4 * w), 32'h0,
               32'h0000_9C30 + 32'(4 * w + 1), w + 1);

    // R8: single-word stores
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 4; k++)
        run_op(d, 1'b1, 1'b0, 2'd2, 32'h0000_7000 + 32'(4 * k + k), 32'hA5A50000 + 32'(k),
               32'h0, k + 2 * d);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule